// File: doc/BRIEF.md
# Programmable Interval Timer with Software-Set Interrupt Vector

This block is a bus-attached periodic timer. Software loads an interval length, in bus clock cycles, into a reload register. It then writes a control word that turns the timer on and, in the same word, chooses which interrupt vector number and which priority the timer raises. While the timer is on, it counts down once per bus clock. Each time the interval runs out, it emits a one-cycle interrupt request that carries the chosen vector and priority, reloads itself and keeps going. The timer is always periodic. A one-shot delay is built in software: the interrupt handler writes zero to the control register.

Any write to the control register acts as a command. A word with the enable bit set starts a new interval with the reload value held at that moment. A word with the enable bit clear stops the timer at once. Reload writes made while the timer runs are held until the next enable write. A read-only register reports the bus clock period in nanoseconds, so software can convert time into cycles. A build-time compatibility option limits the vector range to 64..127 and folds vector bits into the priority.

The controller is a two-state machine. IDLE is left by the transition ARM, which is an enable write with a nonzero reload. RUN stays in RUN through the transitions TICK (decrement) and EXPIRE (pulse and reload). RUN returns to IDLE through the transition HALT, which is an enable-clear write or an enable write with a zero reload. An enable write made in RUN with a nonzero reload is the transition REARM: the timer stays in RUN and restarts the count.

Top module: `vec_interval_timer`

## Requirements
- R1: After reset the timer is in IDLE. The control, reload and count registers read 0 and the interrupt output is low.
- R2: The byte offsets are: control 0x00, reload 0x10, live count 0x14, bus period 0x18. Any other offset reads 0.
- R3: In the control register, bit 26 is the enable, bits 23:20 hold a 4-bit priority and bits 19:12 hold an 8-bit vector. A readback of this register returns only those fields. All other bits read 0 and have no effect.
- R4: After an enable write with reload N ≥ 1, the interrupt output is high for exactly one cycle in the Nth cycle after the write edge. It repeats every N cycles after that.
- R5: While running, the count register reads N − (k mod N) k cycles after the enable write. It reads 0 while idle.
- R6: A control write with bit 26 clear stops the timer. From the next cycle on, no interrupt is raised and the count reads 0.
- R7: An enable write while the reload register holds 0 leaves the timer idle: no interrupt is raised and the count reads 0.
- R8: A reload write made while the timer runs does not change the current period. The new value takes effect at the next enable write.
- R9: The bus-period register always reads the parameter BUS_PERIOD_NS. Writes to the bus-period and count offsets are ignored.
- R10: With COMPAT = 0, each interrupt pulse carries the programmed vector and priority unchanged.
- R11: With COMPAT = 1, the pulse carries the vector {2'b01, v[5:0]}, where v is the programmed vector. Its priority is v[5:2] OR the programmed priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector number carried with the request |
| irq_prio | output | 4 | Priority carried with the request |

## Verification
The bench builds two copies side by side on one shared bus: one with COMPAT = 0 and one with COMPAT = 1, both with BUS_PERIOD_NS = 20 and a full 32-bit counter. Every write therefore checks the plain field mapping and the folded vector/priority mapping in the same cycle. Random vectors with the top bits set show that the compatibility copy masks them. Short reload values (1 to 9) keep several full periods, including the back-to-back pulses of a period of one, within a short run.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Controller states
    typedef enum logic [0:0] {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    // Register byte offsets
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_RELOAD = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_BUSPD  = 8'h18;

    // Control word field layout
    localparam int EN_BIT   = 26;
    localparam int PRIO_LSB = 20;
    localparam int PRIO_W   = 4;
    localparam int VEC_LSB  = 12;
    localparam int VEC_W    = 8;

    localparam logic [31:0] CTRL_MASK =
        (32'h1 << EN_BIT)
        | (((32'h1 << PRIO_W) - 32'h1) << PRIO_LSB)
        | (((32'h1 << VEC_W) - 32'h1) << VEC_LSB);

endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
    import ivt_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [CNT_W-1:0]  count_val,
    output logic [31:0]       bus_rdata,
    output logic              arm,
    output logic              disarm,
    output logic [CNT_W-1:0]  reload_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic [PRIO_W-1:0] prio_q
);

    logic sel_ctrl, sel_reload, sel_count, sel_buspd;
    logic en_q;
    logic unused_wdata;

    assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
    assign sel_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
    assign sel_count  = (bus_addr == ADDR_W'(OFS_COUNT));
    assign sel_buspd  = (bus_addr == ADDR_W'(OFS_BUSPD));

    // Control writes are commands to the controller
    assign arm    = bus_wr & sel_ctrl &  bus_wdata[EN_BIT];
    assign disarm = bus_wr & sel_ctrl & ~bus_wdata[EN_BIT];

    assign unused_wdata = ^{bus_wdata[31:EN_BIT+1], bus_wdata[EN_BIT-1:PRIO_LSB+PRIO_W],
                            bus_wdata[VEC_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            vec_q    <= '0;
            prio_q   <= '0;
            reload_q <= '0;
        end else if (bus_wr) begin
            if (sel_ctrl) begin
                en_q   <= bus_wdata[EN_BIT];
                prio_q <= bus_wdata[PRIO_LSB +: PRIO_W];
                vec_q  <= bus_wdata[VEC_LSB +: VEC_W];
            end
            if (sel_reload) begin
                reload_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_ctrl) begin
            bus_rdata[EN_BIT]               = en_q;
            bus_rdata[PRIO_LSB +: PRIO_W]   = prio_q;
            bus_rdata[VEC_LSB +: VEC_W]     = vec_q;
        end else if (sel_reload) begin
            bus_rdata = 32'(reload_q);
        end else if (sel_count) begin
            bus_rdata = 32'(count_val);
        end else if (sel_buspd) begin
            bus_rdata = 32'(BUS_PERIOD_NS);
        end
    end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
    import ivt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic [CNT_W-1:0] reload,
    output logic             irq_q,
    output logic             run,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] active_q
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e state_q, state_d;
    logic       reload_zero;
    logic       expire;

    assign reload_zero = (reload == '0);
    assign expire      = (state_q == TMR_RUN) && (count_q == ONE) && !arm && !disarm;
    assign run         = (state_q == TMR_RUN);

    // Next-state logic: ARM, REARM, TICK, EXPIRE, HALT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (arm && !reload_zero) state_d = TMR_RUN;   // ARM
            end
            TMR_RUN: begin
                if (disarm || (arm && reload_zero)) state_d = TMR_IDLE;  // HALT
            end
            default: state_d = TMR_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TMR_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            active_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= expire;
            if (arm && !reload_zero) begin
                count_q  <= reload;        // ARM / REARM
                active_q <= reload;
            end else if (state_d == TMR_IDLE) begin
                count_q  <= '0;            // HALT or idle
            end else if (count_q == ONE) begin
                count_q  <= active_q;      // EXPIRE
            end else begin
                count_q  <= count_q - ONE; // TICK
            end
        end
    end

endmodule

// File: rtl/ivt_vecmap.sv
module ivt_vecmap
    import ivt_pkg::*;
#(
    parameter bit COMPAT = 1'b0
) (
    input  logic [VEC_W-1:0]  vec_q,
    input  logic [PRIO_W-1:0] prio_q,
    output logic [VEC_W-1:0]  irq_vector,
    output logic [PRIO_W-1:0] irq_prio
);

    generate
        if (COMPAT) begin : g_compat
            logic [VEC_W-1:0] vec_eff;
            logic             unused_top;
            assign unused_top = ^vec_q[VEC_W-1:VEC_W-2];
            assign vec_eff    = {2'b01, vec_q[VEC_W-3:0]};
            assign irq_vector = vec_eff;
            assign irq_prio   = vec_eff[2 +: PRIO_W] | prio_q;
        end else begin : g_plain
            assign irq_vector = vec_q;
            assign irq_prio   = prio_q;
        end
    endgenerate

endmodule

// File: rtl/vec_interval_timer.sv
module vec_interval_timer
    import ivt_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20,
    parameter bit COMPAT        = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_pulse,
    output logic [7:0]        irq_vector,
    output logic [3:0]        irq_prio
);

    logic              arm_w, disarm_w, run_w;
    logic [CNT_W-1:0]  reload_w, count_w, active_w;
    logic [VEC_W-1:0]  vec_w;
    logic [PRIO_W-1:0] prio_w;

    ivt_regs #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_PERIOD_NS(BUS_PERIOD_NS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count_val(count_w), .bus_rdata(bus_rdata),
        .arm(arm_w), .disarm(disarm_w), .reload_q(reload_w),
        .vec_q(vec_w), .prio_q(prio_w)
    );

    ivt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .arm(arm_w), .disarm(disarm_w),
        .reload(reload_w), .irq_q(irq_pulse), .run(run_w),
        .count_q(count_w), .active_q(active_w)
    );

    ivt_vecmap #(.COMPAT(COMPAT)) u_map (
        .vec_q(vec_w), .prio_q(prio_w),
        .irq_vector(irq_vector), .irq_prio(irq_prio)
    );

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker
    import ivt_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int CNT_W         = 32,
    parameter int BUS_PERIOD_NS = 20,
    parameter bit COMPAT        = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq_pulse,
    input logic [7:0]        irq_vector,
    input logic [3:0]        irq_prio,
    input logic              run,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  act_reload
);

    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

    // R6
    stop_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[EN_BIT]) |=> (!irq_pulse && !run));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse && act_reload != CNT_W'(1)) |=> !irq_pulse);

    // R4
    pulse_at_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && count == CNT_W'(1) && !ctrl_wr) |=> irq_pulse);

    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count != '0 && count <= act_reload));

    // R7
    pulse_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(run));

    // R9
    bus_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_BUSPD)) |-> (bus_rdata == 32'(BUS_PERIOD_NS)));

    generate
        if (COMPAT) begin : g_compat_chk
            // R11
            compat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_pulse |-> (irq_vector[7:6] == 2'b01));
            // R11
            compat_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_pulse |-> ((irq_prio & irq_vector[5:2]) == irq_vector[5:2]));
        end
    endgenerate

endmodule

bind vec_interval_timer ivt_checker #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BUS_PERIOD_NS(BUS_PERIOD_NS), .COMPAT(COMPAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse),
    .irq_vector(irq_vector), .irq_prio(irq_prio), .run(run_w),
    .count(count_w), .act_reload(active_w)
);

// File: tb/test_vec_interval_timer.sv
module test_vec_interval_timer;

    localparam int CLK_PERIOD = 10;
    localparam int BUSPD      = 20;
    localparam logic [7:0] A_CTRL = 8'h00, A_REL = 8'h10, A_CNT = 8'h14, A_BPD = 8'h18;
    localparam logic [31:0] FIELD_MASK = 32'h04FF_F000;
    localparam logic [31:0] EN = 32'h0400_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_n, rd_c;
    logic        irq_n, irq_c;
    logic [7:0]  vec_n, vec_c;
    logic [3:0]  pri_n, pri_c;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_interval_timer #(.BUS_PERIOD_NS(BUSPD), .COMPAT(1'b0)) i_vec_interval_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_n), .irq_pulse(irq_n),
        .irq_vector(vec_n), .irq_prio(pri_n)
    );

    vec_interval_timer #(.BUS_PERIOD_NS(BUSPD), .COMPAT(1'b1)) i_vec_interval_timer_compat (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_c), .irq_pulse(irq_c),
        .irq_vector(vec_c), .irq_prio(pri_c)
    );

    function automatic logic [7:0] exp_vec(input logic [7:0] v, input bit compat);
        return compat ? {2'b01, v[5:0]} : v;
    endfunction

    function automatic logic [3:0] exp_pri(input logic [7:0] v, input logic [3:0] p, input bit compat);
        return compat ? (v[5:2] | p) : p;
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [7:0] v, input logic [3:0] p);
        return EN | (32'(p) << 20) | (32'(v) << 12);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_CNT; bus_wdata = '0;
    endtask

    task automatic bus_read_both(input logic [7:0] a, input string req,
                                 input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, rd_n, exp);
        check(req, rd_c, exp);
        bus_addr = A_CNT;
    endtask

    // Observe cycles k_from..k_to after the enable edge; n = 0 means idle
    task automatic observe(input int k_from, input int k_to, input int n,
                           input logic [7:0] v, input logic [3:0] p);
        for (int k = k_from; k <= k_to; k++) begin
            bit pulse;
            @(negedge clk);
            #1;
            pulse = (n != 0) && (k % n == 0);
            check("R4 pulse normal", 32'(irq_n), 32'(pulse));
            check("R4 pulse compat", 32'(irq_c), 32'(pulse));
            check("R5 count", rd_n, (n != 0) ? 32'(n - (k % n)) : 32'd0);
            if (pulse) begin
                check("R10 vector", 32'(vec_n), 32'(exp_vec(v, 1'b0)));
                check("R10 prio", 32'(pri_n), 32'(exp_pri(v, p, 1'b0)));
                check("R11 vector", 32'(vec_c), 32'(exp_vec(v, 1'b1)));
                check("R11 prio", 32'(pri_c), 32'(exp_pri(v, p, 1'b1)));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 irq after reset", 32'(irq_n | irq_c), 32'd0);
        bus_read_both(A_CTRL, "R1 ctrl reset", 32'd0);
        bus_read_both(A_REL,  "R1 reload reset", 32'd0);
        bus_read_both(A_CNT,  "R1 count reset", 32'd0);
        // R2 map and unmapped offsets
        bus_read_both(8'h04, "R2 unmapped 04", 32'd0);
        bus_read_both(8'h1C, "R2 unmapped 1C", 32'd0);
        // R9 bus period and ignored writes
        bus_read_both(A_BPD, "R9 bus period", 32'(BUSPD));
        bus_write(A_BPD, 32'hFFFF_FFFF);
        bus_write(A_CNT, 32'h0000_1234);
        bus_read_both(A_BPD, "R9 bus period after write", 32'(BUSPD));
        bus_read_both(A_CNT, "R9 count after write", 32'd0);

        // R7 and R3: enable with zero reload, all bits set
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        bus_read_both(A_CTRL, "R3 field readback", FIELD_MASK);
        observe(1, 12, 0, 8'h00, 4'h0);   // R7 no pulse, count 0

        // R4 R5 directed: period 1 and period 4
        bus_write(A_CTRL, 32'd0);
        bus_write(A_REL, 32'd1);
        bus_write(A_CTRL, ctrl_word(8'hC5, 4'h2));
        observe(1, 5, 1, 8'hC5, 4'h2);
        bus_write(A_CTRL, 32'd0);
        observe(1, 6, 0, 8'h00, 4'h0);    // R6 stopped
        bus_write(A_REL, 32'd4);
        bus_write(A_CTRL, ctrl_word(8'h47, 4'h8) | 32'hF800_0FFF);  // R3 junk bits
        observe(1, 13, 4, 8'h47, 4'h8);

        // R8 reload change while running keeps period 4 until re-enable
        bus_write(A_REL, 32'd7);
        observe(16, 30, 4, 8'h47, 4'h8);
        bus_write(A_CTRL, ctrl_word(8'h47, 4'h8));
        observe(1, 15, 7, 8'h47, 4'h8);

        // R6 disable stops everything
        bus_write(A_CTRL, 32'd0);
        observe(1, 20, 0, 8'h00, 4'h0);

        // Random periods, vectors and priorities
        for (int it = 0; it < 8; it++) begin
            int n;
            logic [7:0] v;
            logic [3:0] p;
            logic [31:0] junk;
            n = int'($urandom_range(1, 9));
            v = 8'($urandom);
            p = 4'($urandom);
            junk = $urandom & ~FIELD_MASK;
            bus_write(A_CTRL, 32'd0);
            bus_write(A_REL, 32'(n));
            bus_write(A_CTRL, ctrl_word(v, p) | junk);
            observe(1, 3 * n + 2, n, v, p);
            bus_read_both(A_CTRL, "R3 random readback", ctrl_word(v, p));
            bus_read_both(A_REL, "R2 reload readback", 32'(n));
        end

        bus_write(A_CTRL, 32'd0);
        observe(1, 5, 0, 8'h00, 4'h0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule